// File: doc/BRIEF.md
# Receive Signal-Detect Qualifier

This block turns the raw, clock-free "energy present" level from a line receiver into a clean detect flag that is synchronous to the rising edge of the receive clock. The raw level rises for any signal above the receiver's minimum amplitude, whatever kind of signal it is. All qualification therefore happens here. The input is synchronized, and a run-length filter then asserts the output only after the synchronized level has stayed high for a programmable number of consecutive clock cycles. Brief activity is rejected: glitches, noise bursts and the isolated link pulses of 10 Mb/s idle. Sustained 100 Mb/s signalling and 10 Mb/s packets are accepted.

The output is also shaped by the operating controls. A low-power request holds it low and discards any partial run. Diagnostic loopback in 100 Mb/s mode forces it high. Loopback in 10 Mb/s mode leaves normal qualification in place. The default filter length of 750 cycles equals 30 µs at a 25 MHz receive clock.

Top module: `sigdet_qualifier`

## Requirements
- R1: While reset is asserted, and at the first edge after reset is released, the output is low and the run count is zero.
- R2: The raw input passes through a two-flop synchronizer, so the qualifier sees an input change at the second rising edge after the change. The output only changes on a rising clock edge.
- R3: A high run shorter than FILTER_CYCLES synchronized samples never asserts the output. This also holds for a train of such runs separated by low gaps.
- R4: If the raw input rises just before rising edge 0 and stays high, the output goes high at edge FILTER_CYCLES+1 and stays high while the input stays high. A run of exactly FILTER_CYCLES samples gives a one-cycle high output.
- R5: While the low-power request (sleepReq=1) is high, the output is low from the next edge on and the run count is held at zero. After the request is released, a full new run of FILTER_CYCLES samples is needed before the output asserts.
- R6: With sleepReq=0, loopEn=1 and speed100=1, the output is high from the next edge, whatever the raw input is.
- R7: With speed100=0, loopEn has no effect, and the output follows normal qualification.
- R8: When the synchronized level is low, the output is low after the next edge (outside loopback in 100 Mb/s mode), and the run count restarts from zero.
- R9: Qualification timing is the same for speed100=0 and speed100=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| rawDet | input | 1 | Asynchronous signal-energy level from the receiver |
| speed100 | input | 1 | 1 selects 100 Mb/s mode, 0 selects 10 Mb/s mode |
| sleepReq | input | 1 | 1 requests low-power mode |
| loopEn | input | 1 | 1 enables diagnostic loopback |
| detOut | output | 1 | Qualified detect, synchronous to clk |

## Verification
A corrupted run count shows up at the port as an assertion that comes one or more cycles early or late against the FILTER_CYCLES+1 edge latency. It can also show up as a spurious one-cycle pulse from a train of short bursts. A count that is not cleared in low power is exposed at the first wake-up: the output rises before a full new run has elapsed. A wrong synchronizer depth shifts both the rise edge and the fall edge by whole cycles. Each of these faults is visible within one filter window of the stimulus.

// File: rtl/sdq_pkg.sv
package sdq_pkg;
  // strobes passed from mode control to the detect datapath
  typedef struct packed {
    logic holdLow;   // force output low
    logic holdHigh;  // force output high
    logic clearRun;  // discard the run count
  } sdqStrobe_t;
endpackage

// File: rtl/sdq_ctrl.sv
module sdq_ctrl
  import sdq_pkg::*;
(
  input  logic       speed100,
  input  logic       sleepReq,
  input  logic       loopEn,
  output sdqStrobe_t strb
);
  // low power outranks loopback; loopback forces only in 100 Mb/s mode
  always_comb begin
    strb.holdLow  = sleepReq;
    strb.holdHigh = !sleepReq && loopEn && speed100;
    strb.clearRun = sleepReq;
  end
endmodule

// File: rtl/sdq_path.sv
module sdq_path
  import sdq_pkg::*;
#(
  parameter int FILTER_CYCLES = 750,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rawDet,
  input  sdqStrobe_t strb,
  output logic       syncLevel,
  output logic       detOut
);
  localparam int CNT_W = $clog2(FILTER_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(FILTER_CYCLES);

  logic [SYNC_STAGES-1:0] syncChain;
  logic [CNT_W-1:0]       runCnt;
  logic [CNT_W-1:0]       runNext;
  logic                   qualified;

  assign syncLevel = syncChain[SYNC_STAGES-1];

  // synchronizer chain, depth chosen by parameter
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[gi] <= 1'b0;
        else if (gi == 0) syncChain[gi] <= rawDet;
        else syncChain[gi] <= syncChain[(gi == 0) ? 0 : gi-1];
      end
    end
  endgenerate

  // saturating run length of consecutive high samples
  always_comb begin
    if (!syncLevel) runNext = '0;
    else if (runCnt == LIMIT) runNext = LIMIT;
    else runNext = runCnt + CNT_W'(1);
    qualified = syncLevel && (runNext == LIMIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
      detOut <= 1'b0;
    end else begin
      runCnt <= strb.clearRun ? '0 : runNext;
      if (strb.holdLow) detOut <= 1'b0;
      else if (strb.holdHigh) detOut <= 1'b1;
      else detOut <= qualified;
    end
  end
endmodule

// File: rtl/sigdet_qualifier.sv
module sigdet_qualifier
  import sdq_pkg::*;
#(
  parameter int FILTER_CYCLES = 750,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawDet,
  input  logic speed100,
  input  logic sleepReq,
  input  logic loopEn,
  output logic detOut
);
  sdqStrobe_t strb;
  logic       syncLevel;

  sdq_ctrl u_ctrl (
    .speed100 (speed100),
    .sleepReq (sleepReq),
    .loopEn   (loopEn),
    .strb     (strb)
  );

  sdq_path #(
    .FILTER_CYCLES (FILTER_CYCLES),
    .SYNC_STAGES   (SYNC_STAGES)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .rawDet    (rawDet),
    .strb      (strb),
    .syncLevel (syncLevel),
    .detOut    (detOut)
  );
endmodule

// File: rtl/sdq_checker.sv
module sdq_checker
  import sdq_pkg::*;
#(
  parameter int FILTER_CYCLES = 750
) (
  input logic       clk,
  input logic       rstN,
  input logic       rawDet,
  input logic       speed100,
  input logic       sleepReq,
  input logic       loopEn,
  input logic       syncLevel,
  input logic       detOut,
  input sdqStrobe_t strb
);
  localparam logic [31:0] LIM = 32'(FILTER_CYCLES);

  logic [31:0] hiRun;
  logic [1:0]  sinceRst;
  logic        normal;

  assign normal = !sleepReq && !(loopEn && speed100);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiRun    <= '0;
      sinceRst <= '0;
    end else begin
      if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
      if (sleepReq || !syncLevel) hiRun <= '0;
      else if (hiRun < LIM) hiRun <= hiRun + 32'd1;
    end
  end

  assert_sync_delay_R2: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2) |-> (syncLevel == $past(rawDet, 2)));

  assert_short_run_R3: assert property (@(posedge clk) disable iff (!rstN)
    (normal && !(syncLevel && hiRun >= LIM - 32'd1)) |=> !detOut);

  assert_full_run_R4: assert property (@(posedge clk) disable iff (!rstN)
    (normal && syncLevel && hiRun >= LIM - 32'd1) |=> detOut);

  assert_sleep_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    sleepReq |=> !detOut);

  assert_loop_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!sleepReq && loopEn && speed100) |=> detOut);

  assert_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (normal && !syncLevel) |=> !detOut);

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.holdLow, strb.holdHigh}));
endmodule

bind sigdet_qualifier sdq_checker #(.FILTER_CYCLES(FILTER_CYCLES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rawDet    (rawDet),
  .speed100  (speed100),
  .sleepReq  (sleepReq),
  .loopEn    (loopEn),
  .syncLevel (syncLevel),
  .detOut    (detOut),
  .strb      (strb)
);

// File: tb/sigdet_qualifier_test.sv
module sigdet_qualifier_test;
  localparam int N = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rawDet = 1'b0;
  logic speed100 = 1'b0;
  logic sleepReq = 1'b0;
  logic loopEn = 1'b0;
  logic detOut;

  int total = 0;
  int failed = 0;
  bit cmpOn = 1'b0;
  bit sawHigh = 1'b0;

  // reference model state
  bit    s0 = 0, s1 = 0, expOut = 0;
  int    run = 0;
  string modeTag = "R1";

  sigdet_qualifier #(.FILTER_CYCLES(N)) uut (
    .clk(clk), .rstN(rstN), .rawDet(rawDet), .speed100(speed100),
    .sleepReq(sleepReq), .loopEn(loopEn), .detOut(detOut)
  );

  always #2 clk = ~clk;

  // behavioural reference, evaluated at each rising edge
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s0 = 0; s1 = 0; run = 0; expOut = 0; modeTag = "R1";
    end else begin
      bit oldS1;
      oldS1 = s1;
      s1 = s0;
      s0 = rawDet;
      if (sleepReq) begin
        run = 0; expOut = 0; modeTag = "R5";
      end else begin
        run = oldS1 ? ((run < N) ? run + 1 : N) : 0;
        if (loopEn && speed100) begin
          expOut = 1; modeTag = "R6";
        end else begin
          expOut = oldS1 && (run >= N);
          modeTag = oldS1 ? "R4" : "R8";
        end
      end
    end
  end

  always @(negedge clk) begin
    if (detOut === 1'b1) sawHigh = 1'b1;
    if (cmpOn) begin
      total++;
      if (detOut !== expOut) begin
        failed++;
        $display("FAIL %s model compare: actual %b expected %b at %0t",
                 modeTag, detOut, expOut, $time);
      end
    end
  end

  task automatic check(input string tag, input bit exp, input string what);
    total++;
    if (detOut !== exp) begin
      failed++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, detOut, exp);
    end
  endtask

  task automatic pulse(input int len, input int gap);
    rawDet = 1'b1;
    repeat (len) @(negedge clk);
    rawDet = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 1'b0, "output during reset");
    rstN = 1'b1;
    @(negedge clk);
    check("R1", 1'b0, "output after reset release");
    cmpOn = 1'b1;

    // R3: run one short of the limit
    sawHigh = 0;
    pulse(N - 1, 6);
    total++;
    if (sawHigh) begin failed++; $display("FAIL R3 run N-1: actual 1 expected 0"); end

    // R3: link-pulse-like train
    sawHigh = 0;
    for (int i = 0; i < 25; i++) pulse(3, 2);
    repeat (4) @(negedge clk);
    total++;
    if (sawHigh) begin failed++; $display("FAIL R3 pulse train: actual 1 expected 0"); end

    // R4: run of exactly N gives a pulse
    sawHigh = 0;
    pulse(N, 6);
    total++;
    if (!sawHigh) begin failed++; $display("FAIL R4 run N: actual 0 expected 1"); end

    // R4 latency at 10 Mb/s, then R8 drop
    rawDet = 1'b1;
    repeat (N + 1) @(negedge clk);
    check("R4", 1'b0, "one edge before qualification");
    @(negedge clk);
    check("R4", 1'b1, "qualified at edge N+1");
    repeat (10) @(negedge clk);
    check("R4", 1'b1, "held while input high");
    rawDet = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R2", 1'b1, "still high inside sync delay");
    @(negedge clk);
    check("R8", 1'b0, "drop after sync delay");

    // R5: low power with active input
    rawDet = 1'b1;
    repeat (N + 4) @(negedge clk);
    check("R5", 1'b1, "high before sleep");
    sleepReq = 1'b1;
    @(negedge clk);
    check("R5", 1'b0, "low one edge into sleep");
    repeat (30) @(negedge clk);
    check("R5", 1'b0, "held low in sleep");
    sleepReq = 1'b0;
    repeat (N - 1) @(negedge clk);
    check("R5", 1'b0, "run restarts after sleep");
    @(negedge clk);
    check("R5", 1'b1, "full run after sleep");
    rawDet = 1'b0;
    repeat (4) @(negedge clk);

    // R6: loopback at 100 Mb/s forces high
    speed100 = 1'b1;
    loopEn = 1'b1;
    @(negedge clk);
    check("R6", 1'b1, "loopback forces high");
    repeat (5) @(negedge clk);
    check("R6", 1'b1, "loopback holds high");
    sleepReq = 1'b1;
    @(negedge clk);
    check("R5", 1'b0, "sleep outranks loopback");
    sleepReq = 1'b0;
    loopEn = 1'b0;
    repeat (3) @(negedge clk);
    check("R6", 1'b0, "loopback released");

    // R9: same latency at 100 Mb/s
    rawDet = 1'b1;
    repeat (N + 1) @(negedge clk);
    check("R9", 1'b0, "100M one edge before");
    @(negedge clk);
    check("R9", 1'b1, "100M qualified at edge N+1");
    rawDet = 1'b0;
    repeat (4) @(negedge clk);

    // R7: loopback at 10 Mb/s has no effect
    speed100 = 1'b0;
    loopEn = 1'b1;
    sawHigh = 0;
    pulse(N - 1, 6);
    total++;
    if (sawHigh) begin failed++; $display("FAIL R7 loopback at 10M: actual 1 expected 0"); end
    loopEn = 1'b0;

    cmpOn = 1'b0;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    #(200000 * 4);
    total++;
    failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule